// File: doc/BRIEF.md
# Serial DAC Write Controller

This block takes 14-bit conversion codes from logic in the system-clock domain and writes them to a current-output multiplying DAC over a three-wire link. The three wires are an active-low chip select, a serial clock and a data line. A code is offered with a valid/ready handshake. The controller pulls chip select low and presents the frame one bit per serial clock period, most significant bit first. The receiver samples each bit on the rising clock edge. After the last bit, chip select is held low for a hold interval and then raised. The converter commits the word on that rising edge of chip select.

The serial clock is built entirely from system-clock cycles. Its high time, its low time and the chip-select hold time are separate parameters, each counted in cycles. Choose them so that the link meets the converter's limits: at least 10 ns high, at least 10 ns low, a serial clock no faster than 50 MHz, and at least 10 ns of chip-select hold after the last rising edge. The data line changes only while the serial clock is low, so setup and hold margins come from the low and high widths.

The frame may be 14 or 16 bits long. The receiver keeps only the last 14 bits clocked in before chip select rises, so in 16-bit mode the two leading bits are sent as zeros.

Top module: `dac_serial_writer`

## Requirements
- R1: A synchronous reset puts the outputs in their idle levels by the first clock edge, and this also aborts any frame in progress. Idle levels are chip select high, serial clock low, done low, ready high and busy low.
- R2: A code is accepted at a clock edge where valid and ready are both high. From the next cycle, chip select is low and ready is low, and busy is high.
- R3: The frame is sent most significant bit first. With FRAME_W = 16, the receiver collects the bits 0, 0, then code bit 13 down to code bit 0. The 14 bits it holds when chip select rises are the accepted code.
- R4: Each serial clock high phase lasts exactly T_HIGH system cycles. Each low phase inside a frame lasts exactly T_LOW cycles, and this includes the phase from the fall of chip select to the first rising edge.
- R5: The data line changes only in cycles where the serial clock is low. It never changes in the cycle the clock rises or while the clock is high.
- R6: Each frame has exactly FRAME_W rising serial clock edges, and all of them occur while chip select is low. The serial clock is never high while chip select is high.
- R7: Chip select rises exactly T_HIGH + T_HOLD cycles after the last rising serial clock edge of the frame, with the serial clock low.
- R8: Done is high for exactly one cycle per frame, and that cycle is the one in which chip select goes high.
- R9: When the next code is already waiting, chip select stays high for exactly T_HIGH + 1 cycles between frames.
- R10: Valid is ignored while a frame is in progress. A code offered during that time neither changes the frame being sent nor starts a new one.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | System clock |
| rst | input | 1 | Synchronous reset, active high |
| code_valid | input | 1 | Code offered |
| code_in | input | CODE_W | Code to write |
| code_ready | output | 1 | Controller can take a code |
| busy | output | 1 | A frame is in progress |
| done | output | 1 | One-cycle pulse when chip select rises |
| cs_n | output | 1 | Chip select to the converter, active low |
| sclk | output | 1 | Serial clock to the converter |
| sdi | output | 1 | Serial data to the converter |

## Verification
The assertions assume that the handshake inputs come from logic timed to the same clock and that reset is held across at least one clock edge. They make no assumption about whether valid stays high, because acceptance depends only on ready. The stimulus changes valid, the code and reset half a period away from the active edge. It deliberately keeps valid high while a frame is running, and again after a commit, so that both the ignore case and the back-to-back case occur. Reset is applied once in the middle of a frame, and a fresh write follows it.

// File: rtl/dacw_pkg.sv
package dacw_pkg;

    typedef enum logic [2:0] {
        ST_IDLE,
        ST_LOW,
        ST_HIGH,
        ST_HOLD,
        ST_GAP
    } dacw_state_e;

endpackage

// File: rtl/dacw_phase_timer.sv
module dacw_phase_timer #(
    parameter int CNT_W = 2
) (
    input  logic             clk,
    input  logic             rst,
    input  logic             load,
    input  logic [CNT_W-1:0] load_val,
    output logic             expired
);

    logic [CNT_W-1:0] cnt_d, cnt_q;

    always_comb begin
        cnt_d = cnt_q;
        if (load) begin
            cnt_d = load_val;
        end else if (cnt_q != '0) begin
            cnt_d = cnt_q - 1'b1;
        end
        if (rst) begin
            cnt_d = '0;
        end
    end

    always_ff @(posedge clk) begin
        cnt_q <= cnt_d;
    end

    assign expired = (cnt_q == '0);

endmodule

// File: rtl/dacw_shreg.sv
module dacw_shreg #(
    parameter int W = 16
) (
    input  logic         clk,
    input  logic         rst,
    input  logic         load,
    input  logic         shift,
    input  logic         clear,
    input  logic [W-1:0] load_val,
    output logic         msb
);

    logic [W-1:0] sh_d, sh_q;

    always_comb begin
        sh_d = sh_q;
        if (clear) begin
            sh_d = '0;
        end else if (load) begin
            sh_d = load_val;
        end else if (shift) begin
            sh_d = {sh_q[W-2:0], 1'b0};
        end
        if (rst) begin
            sh_d = '0;
        end
    end

    always_ff @(posedge clk) begin
        sh_q <= sh_d;
    end

    assign msb = sh_q[W-1];

    // R3: only one operation on the frame word per cycle
    p_one_op_r3: assert property (@(posedge clk) disable iff (rst)
        !(load && shift) && !(load && clear) && !(shift && clear));

endmodule

// File: rtl/dac_serial_writer.sv
module dac_serial_writer
    import dacw_pkg::*;
#(
    parameter int CODE_W  = 14,
    parameter int FRAME_W = 16,
    parameter int T_HIGH  = 2,
    parameter int T_LOW   = 2,
    parameter int T_HOLD  = 2
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              code_valid,
    input  logic [CODE_W-1:0] code_in,
    output logic              code_ready,
    output logic              busy,
    output logic              done,
    output logic              cs_n,
    output logic              sclk,
    output logic              sdi
);

    localparam int PAD_W = FRAME_W - CODE_W;
    localparam int BIT_W = $clog2(FRAME_W);
    localparam int T_MAX = (T_HIGH > T_LOW) ? ((T_HIGH > T_HOLD) ? T_HIGH : T_HOLD)
                                            : ((T_LOW > T_HOLD) ? T_LOW : T_HOLD);
    localparam int CNT_W = $clog2(T_MAX) + 1;
    localparam logic [CNT_W-1:0] LD_HIGH   = CNT_W'(T_HIGH - 1);
    localparam logic [CNT_W-1:0] LD_LOW    = CNT_W'(T_LOW - 1);
    localparam logic [CNT_W-1:0] LD_HOLD   = CNT_W'(T_HOLD - 1);
    localparam logic [BIT_W-1:0] BITS_LAST = BIT_W'(FRAME_W - 1);

    typedef struct packed {
        dacw_state_e      state;
        logic [BIT_W-1:0] bits;
        logic             cs_n;
        logic             sclk;
        logic             done;
    } ctl_t;

    localparam ctl_t CTL_IDLE = '{state: ST_IDLE, bits: '0, cs_n: 1'b1, sclk: 1'b0, done: 1'b0};

    ctl_t             d, q;
    logic             tmr_load, tmr_expired;
    logic [CNT_W-1:0] tmr_val;
    logic             sh_load, sh_shift, sh_clear;
    logic [FRAME_W-1:0] frame_word;

    generate
        if (PAD_W == 0) begin : g_nopad
            assign frame_word = code_in;
        end else begin : g_pad
            assign frame_word = {{PAD_W{1'b0}}, code_in};
        end
    endgenerate

    always_comb begin
        d        = q;
        d.done   = 1'b0;
        tmr_load = 1'b0;
        tmr_val  = '0;
        sh_load  = 1'b0;
        sh_shift = 1'b0;
        sh_clear = 1'b0;
        case (q.state)
            ST_IDLE: begin
                if (code_valid) begin
                    d.state  = ST_LOW;
                    d.cs_n   = 1'b0;
                    d.bits   = BITS_LAST;
                    sh_load  = 1'b1;
                    tmr_load = 1'b1;
                    tmr_val  = LD_LOW;
                end
            end
            ST_LOW: begin
                if (tmr_expired) begin
                    d.state  = ST_HIGH;
                    d.sclk   = 1'b1;
                    tmr_load = 1'b1;
                    tmr_val  = LD_HIGH;
                end
            end
            ST_HIGH: begin
                if (tmr_expired) begin
                    d.sclk   = 1'b0;
                    tmr_load = 1'b1;
                    if (q.bits == '0) begin
                        d.state = ST_HOLD;
                        tmr_val = LD_HOLD;
                    end else begin
                        d.state  = ST_LOW;
                        d.bits   = q.bits - 1'b1;
                        sh_shift = 1'b1;
                        tmr_val  = LD_LOW;
                    end
                end
            end
            ST_HOLD: begin
                if (tmr_expired) begin
                    d.state  = ST_GAP;
                    d.cs_n   = 1'b1;
                    d.done   = 1'b1;
                    sh_clear = 1'b1;
                    tmr_load = 1'b1;
                    tmr_val  = LD_HIGH;
                end
            end
            ST_GAP: begin
                if (tmr_expired) begin
                    d.state = ST_IDLE;
                end
            end
            default: d = CTL_IDLE;
        endcase
        if (rst) begin
            d = CTL_IDLE;
        end
    end

    always_ff @(posedge clk) begin
        q <= d;
    end

    dacw_phase_timer #(.CNT_W(CNT_W)) u_timer (
        .clk      (clk),
        .rst      (rst),
        .load     (tmr_load),
        .load_val (tmr_val),
        .expired  (tmr_expired)
    );

    dacw_shreg #(.W(FRAME_W)) u_shreg (
        .clk      (clk),
        .rst      (rst),
        .load     (sh_load),
        .shift    (sh_shift),
        .clear    (sh_clear),
        .load_val (frame_word),
        .msb      (sdi)
    );

    assign code_ready = (q.state == ST_IDLE);
    assign busy       = (q.state != ST_IDLE);
    assign done       = q.done;
    assign cs_n       = q.cs_n;
    assign sclk       = q.sclk;

    // R2: an accepted code opens a frame and closes the handshake
    p_accept_opens_frame_r2: assert property (@(posedge clk) disable iff (rst)
        (code_valid && code_ready) |=> (!cs_n && !code_ready && busy));

    // R5: data is steady whenever the serial clock is high
    p_data_steady_r5: assert property (@(posedge clk) disable iff (rst)
        sclk |-> $stable(sdi));

    // R6: no serial clock activity outside a frame
    p_clock_in_frame_r6: assert property (@(posedge clk) disable iff (rst)
        sclk |-> !cs_n);

    // R7: chip select rises only after a low-clock hold cycle
    p_hold_before_commit_r7: assert property (@(posedge clk) disable iff (rst)
        $rose(cs_n) |-> (!sclk && $past(!cs_n && !sclk)));

    // R8: done marks the rise of chip select
    p_done_on_commit_r8: assert property (@(posedge clk) disable iff (rst)
        done |-> $rose(cs_n));

    // R10: a frame in progress keeps the handshake closed
    p_busy_blocks_accept_r10: assert property (@(posedge clk) disable iff (rst)
        (!cs_n && !$rose(cs_n)) |-> !code_ready);

endmodule

// File: tb/sim_dac_serial_writer.sv
`timescale 1ns/1ps
module sim_dac_serial_writer;

    localparam int CODE_W  = 14;
    localparam int FRAME_W = 16;
    localparam int TH      = 2;
    localparam int TL      = 3;
    localparam int TD      = 2;
    localparam int NVEC    = 8;

    localparam logic [CODE_W-1:0] VEC_CODE [NVEC] = '{
        14'h0000, 14'h3FFF, 14'h2AAA, 14'h1555,
        14'h2000, 14'h0001, 14'h1234, 14'h3C0F
    };

    logic              clk = 1'b0;
    logic              rst = 1'b1;
    logic              code_valid = 1'b0;
    logic [CODE_W-1:0] code_in = '0;
    logic              code_ready, busy, done, cs_n, sclk, sdi;

    always #2.5 clk = ~clk;

    dac_serial_writer #(
        .CODE_W(CODE_W), .FRAME_W(FRAME_W),
        .T_HIGH(TH), .T_LOW(TL), .T_HOLD(TD)
    ) u0 (
        .clk(clk), .rst(rst), .code_valid(code_valid), .code_in(code_in),
        .code_ready(code_ready), .busy(busy), .done(done),
        .cs_n(cs_n), .sclk(sclk), .sdi(sdi)
    );

    int checks = 0;
    int fails  = 0;

    task automatic check(input bit ok, input string req, input longint act, input longint exp);
        checks++;
        if (!ok) begin
            fails++;
            $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
        end
    endtask

    // receiver-side monitor, sampled away from the active edge
    logic               prev_cs = 1'b1, prev_sclk = 1'b0, prev_sdi = 1'b0;
    logic [FRAME_W-1:0] cap = '0, frame_word = '0;
    int edges = 0, frame_edges = 0, commits = 0;
    int low_run = 0, high_run = 0, since_rise = 0, last_hold = 0;
    int gap_run = 0, last_gap = 0;
    int width_err = 0, sdi_err = 0, stray_edges = 0, done_cnt = 0, done_bad = 0;

    always @(negedge clk) begin
        if (rst) begin
            prev_cs = 1'b1; prev_sclk = 1'b0; prev_sdi = 1'b0;
            edges = 0; low_run = 0; high_run = 0; gap_run = 0;
        end else begin
            if (done) begin
                done_cnt++;
                if (!(cs_n && !prev_cs)) done_bad++;
            end
            if (sclk && sdi != prev_sdi) sdi_err++;
            if (!sclk && prev_sclk) begin
                if (high_run != TH) width_err++;
                high_run = 0;
            end
            if (sclk && !prev_sclk) begin
                if (cs_n) stray_edges++;
                else begin
                    cap = {cap[FRAME_W-2:0], sdi};
                    edges++;
                end
                if (low_run != TL) width_err++;
                low_run = 0;
                since_rise = 0;
            end else begin
                since_rise++;
            end
            if (cs_n && !prev_cs) begin
                frame_word  = cap;
                frame_edges = edges;
                edges       = 0;
                commits++;
                last_hold   = since_rise;
                gap_run     = 0;
            end
            if (!cs_n && prev_cs) begin
                last_gap = gap_run;
                low_run  = 0;
            end
            if (sclk) high_run++;
            else if (!cs_n) low_run++;
            if (cs_n) gap_run++;
            prev_cs = cs_n; prev_sclk = sclk; prev_sdi = sdi;
        end
    end

    task automatic tick();
        @(negedge clk);
        #1;
    endtask

    task automatic wait_ready();
        for (int i = 0; i < 1000 && !code_ready; i++) tick();
    endtask

    task automatic wait_commit(input int c0);
        for (int i = 0; i < 1000 && commits == c0; i++) tick();
    endtask

    task automatic check_frame(input logic [CODE_W-1:0] code, input int d0, input string tag);
        check(frame_word == FRAME_W'(code), {"R3 word ", tag}, frame_word, FRAME_W'(code));
        check(frame_edges == FRAME_W, {"R6 edges ", tag}, frame_edges, FRAME_W);
        check(last_hold == TH + TD, {"R7 hold ", tag}, last_hold, TH + TD);
        check(width_err == 0, {"R4 widths ", tag}, width_err, 0);
        check(sdi_err == 0, {"R5 data steady ", tag}, sdi_err, 0);
        check(stray_edges == 0, {"R6 stray edges ", tag}, stray_edges, 0);
        check(done_cnt - d0 == 1 && done_bad == 0, {"R8 done ", tag}, done_cnt - d0, 1);
    endtask

    task automatic send_frame(input logic [CODE_W-1:0] code, input string tag);
        int c0, d0;
        wait_ready();
        c0 = commits; d0 = done_cnt;
        code_valid = 1'b1; code_in = code;
        tick();
        code_valid = 1'b0;
        check(!cs_n && !code_ready && busy, {"R2 accept ", tag}, {cs_n, code_ready, busy}, 3'b001);
        wait_commit(c0);
        check_frame(code, d0, tag);
    endtask

    initial begin
        #1000000;
        checks++;
        fails++;
        $display("FAIL watchdog expired");
        $display("%0d/%0d checks passed", checks - fails, checks);
        $finish;
    end

    initial begin
        int c0, d0;
        bit ok;
        // R1: reset state
        tick(); tick(); tick();
        check(cs_n && !sclk && !done && code_ready && !busy, "R1 reset idle",
              {cs_n, sclk, done, code_ready, busy}, 5'b10010);
        rst = 1'b0;
        tick();

        // main table of codes
        for (int v = 0; v < NVEC; v++) begin
            send_frame(VEC_CODE[v], $sformatf("vec%0d", v));
        end

        // R10: valid held during a frame is ignored
        wait_ready();
        c0 = commits; d0 = done_cnt;
        code_valid = 1'b1; code_in = 14'h0ABC;
        tick();
        code_in = 14'h3333;
        ok = 1'b1;
        for (int i = 0; i < 40; i++) begin
            if (code_ready) ok = 1'b0;
            tick();
        end
        code_valid = 1'b0;
        check(ok, "R10 ready low while busy", ok, 1);
        wait_commit(c0);
        check_frame(14'h0ABC, d0, "r10");
        wait_ready();
        for (int i = 0; i < 10; i++) tick();
        check(cs_n && commits == c0 + 1, "R10 no extra frame", commits - c0, 1);

        // R9: back-to-back codes
        wait_ready();
        c0 = commits; d0 = done_cnt;
        code_valid = 1'b1; code_in = 14'h1111;
        tick();
        code_in = 14'h2222;
        wait_commit(c0);
        check_frame(14'h1111, d0, "b2b first");
        for (int i = 0; i < 100 && cs_n; i++) tick();
        code_valid = 1'b0;
        check(last_gap == TH + 1, "R9 gap", last_gap, TH + 1);
        c0 = commits; d0 = done_cnt;
        wait_commit(c0);
        check_frame(14'h2222, d0, "b2b second");

        // R1: reset in the middle of a frame
        wait_ready();
        code_valid = 1'b1; code_in = 14'h3FFF;
        tick();
        code_valid = 1'b0;
        for (int i = 0; i < 20; i++) tick();
        d0 = done_cnt;
        rst = 1'b1;
        tick();
        check(cs_n && !sclk && !done && !busy && code_ready, "R1 mid-frame reset",
              {cs_n, sclk, done, busy, code_ready}, 5'b10001);
        rst = 1'b0;
        for (int i = 0; i < 5; i++) tick();
        check(done_cnt == d0 && cs_n && !busy, "R1 frame discarded", done_cnt - d0, 0);
        send_frame(14'h0155, "after reset");

        $display("%0d/%0d checks passed", checks - fails, checks);
        $finish;
    end

endmodule